// File: doc/BRIEF.md
# Timer Event to ADC Trigger Router

This block sits between the timer channels of a chip and its analog-to-digital converter. Each timer channel (and one periodic timer) drives a level flag into the block. When a flag rises and its route is enabled, the block captures the event, pulses an acknowledge back to that source so it can clear its flag, and then issues a single one-cycle trigger to the converter. The trigger carries a conversion channel number that comes from a per-event route register.

Events are held in a pending set until the converter can take them. A trigger is only issued while the converter reports that it is not busy, and after a trigger no further trigger leaves until the converter signals that the conversion is done. When several events wait at the same time, the one with the lowest index is served first. A second rise of an event that is still waiting is folded into the first. Every trigger can also raise a one-cycle interrupt pulse, gated by a global enable bit.

The sequencer has three states. In `ST_IDLE` it waits. The transition *launch* (from `ST_IDLE` to `ST_FIRE`) is taken when at least one event is pending and the converter is not busy. The launch serves the winning event and removes it from the pending set. In `ST_FIRE` the trigger is driven for one cycle. The transition *finish-early* (from `ST_FIRE` to `ST_IDLE`) is taken when done is already high. Otherwise the transition *hold* (from `ST_FIRE` to `ST_WAIT`) is taken. In `ST_WAIT` the sequencer waits, and the transition *release* (from `ST_WAIT` to `ST_IDLE`) is taken on done.

Top module: `timer_adc_xtrig`

## Requirements
- R1: After reset the outputs `adc_trig`, `irq` and `evt_ack` are all zero, and every route register and the interrupt-enable register read back as zero.
- R2: A write to address `i` (with `i < NUM_EVT`) stores `cfg_wdata`, where bit 6 is the route enable and bits 5:0 are the conversion channel. A write to address `NUM_EVT` stores bit 0 as the interrupt enable. `cfg_rdata` returns the stored value of the addressed register in the same bit positions.
- R3: A rising edge of an enabled event flag is sampled on a clock edge. In the cycle after that edge, the matching bit of `evt_ack` is high for exactly one cycle, and no other bit of `evt_ack` is high.
- R4: With the sequencer idle and the converter not busy, `adc_trig` goes high exactly one cycle after the event is captured and stays high for exactly one cycle. While `adc_trig` is high, `adc_chan` equals the channel field of that event's route register.
- R5: A rising flag whose route enable is clear is ignored. It produces no acknowledge and no trigger.
- R6: While `adc_busy` is high, no trigger is issued. A pending event fires in the cycle after the first clock edge that samples `adc_busy` low.
- R7: After a trigger, no further trigger is issued until `adc_done` has been sampled high.
- R8: When several events are pending, they are triggered in ascending order of index, one per completed conversion.
- R9: A rise of an event that is already pending is merged into the pending request, so only one trigger results.
- R10: `irq` is high exactly in the cycles in which `adc_trig` is high and the interrupt enable is set. Otherwise it is low.
- R11: A flag held high produces one event only. No further trigger follows until the flag has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_flag | input | NUM_EVT | Event flags from the timer sources |
| evt_ack | output | NUM_EVT | One-cycle acknowledge to each source |
| adc_busy | input | 1 | Converter is busy and must not be triggered |
| adc_done | input | 1 | Converter finished the requested conversion |
| adc_trig | output | 1 | One-cycle conversion request |
| adc_chan | output | CH_W | Conversion channel for the request |
| irq | output | 1 | Interrupt pulse on each trigger when enabled |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (route registers, then the interrupt-enable register) |
| cfg_wdata | input | CH_W+1 | Register write data |
| cfg_rdata | output | CH_W+1 | Register read data for `cfg_addr` |

## Verification
A pending bit that is lost shows up as a trigger that never arrives. A stale pending bit shows up as an extra trigger one cycle after the next done. Either fault is visible within a few cycles of the handshake. A sequencer stuck in the wrong state shows as a trigger that is missing or repeated, or as a trigger that ignores busy or done. The bench observes this on the cycle where the trigger is due. A wrong priority or a wrong channel lookup shows directly on `adc_chan` during the trigger cycle. The bench therefore checks every event route, the order of triggers for simultaneous events, and the exact cycle of each acknowledge and trigger.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2
    } xt_state_e;
endpackage

// File: rtl/xtrig_cfg_regs.sv
module xtrig_cfg_regs #(
    parameter int NUM_EVT = 29,
    parameter int CH_W    = 6,
    parameter int AW      = $clog2(NUM_EVT + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [AW-1:0]                   cfg_addr,
    input  logic [CH_W:0]                   cfg_wdata,
    output logic [CH_W:0]                   cfg_rdata,
    output logic [NUM_EVT-1:0]              en_vec,
    output logic [NUM_EVT-1:0][CH_W-1:0]    chan_tbl,
    output logic                            irq_en
);
    localparam logic [AW-1:0] IRQ_ADDR = AW'(NUM_EVT);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_route
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_vec[g]   <= 1'b0;
                chan_tbl[g] <= '0;
            end else if (cfg_we && cfg_addr == AW'(g)) begin
                en_vec[g]   <= cfg_wdata[CH_W];
                chan_tbl[g] <= cfg_wdata[CH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (cfg_we && cfg_addr == IRQ_ADDR)
            irq_en <= cfg_wdata[0];
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr < IRQ_ADDR)
            cfg_rdata = {en_vec[cfg_addr], chan_tbl[cfg_addr]};
        else if (cfg_addr == IRQ_ADDR)
            cfg_rdata[0] = irq_en;
    end
endmodule

// File: rtl/xtrig_evt_capture.sv
module xtrig_evt_capture #(
    parameter int NUM_EVT = 29,
    parameter int IW      = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_flag,
    input  logic [NUM_EVT-1:0] en_vec,
    input  logic               clr_valid,
    input  logic [IW-1:0]      clr_idx,
    output logic [NUM_EVT-1:0] pend,
    output logic [NUM_EVT-1:0] evt_ack
);
    logic [NUM_EVT-1:0] flag_q;
    logic [NUM_EVT-1:0] accept;
    logic [NUM_EVT-1:0] pend_n;

    // An edge only counts when its route is enabled.
    assign accept = evt_flag & ~flag_q & en_vec;

    always_comb begin
        pend_n = pend;
        if (clr_valid)
            pend_n[clr_idx] = 1'b0;
        // A new capture wins over a clear of the same bit; a repeat rise merges.
        pend_n = pend_n | accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= '0;
            pend    <= '0;
            evt_ack <= '0;
        end else begin
            flag_q  <= evt_flag;
            pend    <= pend_n;
            evt_ack <= accept;
        end
    end

    p_ack_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack & ~$past(en_vec)) == '0);

    p_ack_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack & ~$past(evt_flag)) == '0);
endmodule

// File: rtl/xtrig_prio_pick.sv
module xtrig_prio_pick #(
    parameter int NUM_EVT = 29,
    parameter int IW      = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0] req,
    output logic               valid,
    output logic [IW-1:0]      idx
);
    // Scan from the top down, so the lowest set index is the one left standing.
    always_comb begin
        idx = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (req[i])
                idx = IW'(i);
        end
    end

    assign valid = |req;
endmodule

// File: rtl/timer_adc_xtrig.sv
module timer_adc_xtrig
    import xtrig_pkg::*;
#(
    parameter int NUM_EVT = 29,
    parameter int CH_W    = 6,
    parameter int AW      = $clog2(NUM_EVT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_flag,
    output logic [NUM_EVT-1:0] evt_ack,
    input  logic               adc_busy,
    input  logic               adc_done,
    output logic               adc_trig,
    output logic [CH_W-1:0]    adc_chan,
    output logic               irq,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [CH_W:0]      cfg_wdata,
    output logic [CH_W:0]      cfg_rdata
);
    localparam int IW = $clog2(NUM_EVT);

    logic [NUM_EVT-1:0]           en_vec;
    logic [NUM_EVT-1:0][CH_W-1:0] chan_tbl;
    logic                         irq_en;
    logic [NUM_EVT-1:0]           pend;
    logic                         pick_valid;
    logic [IW-1:0]                pick_idx;
    logic                         launch;
    logic [CH_W-1:0]              chan_q;
    xt_state_e                    state_q, state_n;

    xtrig_cfg_regs #(.NUM_EVT(NUM_EVT), .CH_W(CH_W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .en_vec   (en_vec),
        .chan_tbl (chan_tbl),
        .irq_en   (irq_en)
    );

    xtrig_evt_capture #(.NUM_EVT(NUM_EVT), .IW(IW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_flag (evt_flag),
        .en_vec   (en_vec),
        .clr_valid(launch),
        .clr_idx  (pick_idx),
        .pend     (pend),
        .evt_ack  (evt_ack)
    );

    xtrig_prio_pick #(.NUM_EVT(NUM_EVT), .IW(IW)) u_pick (
        .req  (pend),
        .valid(pick_valid),
        .idx  (pick_idx)
    );

    assign launch = (state_q == ST_IDLE) && pick_valid && !adc_busy;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_n = ST_FIRE;
            ST_FIRE: state_n = adc_done ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (adc_done) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_n;
            if (launch)
                chan_q <= chan_tbl[pick_idx];
        end
    end

    always_comb begin
        adc_trig = (state_q == ST_FIRE);
        adc_chan = chan_q;
        irq      = adc_trig && irq_en;
    end

    // Conversion-outstanding tracker, kept for the checks only.
    logic outstanding_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            outstanding_q <= 1'b0;
        else if (adc_trig && !adc_done)
            outstanding_q <= 1'b1;
        else if (adc_done)
            outstanding_q <= 1'b0;
    end

    p_trig_idle_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> !$past(adc_busy));

    p_trig_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    p_one_per_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> !outstanding_q);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (adc_trig && irq_en));
endmodule

// File: tb/timer_adc_xtrig_bench.sv
module timer_adc_xtrig_bench;
    localparam int NUM_EVT = 29;
    localparam int CH_W    = 6;
    localparam int AW      = $clog2(NUM_EVT + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_flag = '0;
    logic [NUM_EVT-1:0] evt_ack;
    logic               adc_busy = 1'b0;
    logic               adc_done = 1'b0;
    logic               adc_trig;
    logic [CH_W-1:0]    adc_chan;
    logic               irq;
    logic               cfg_we = 1'b0;
    logic [AW-1:0]      cfg_addr = '0;
    logic [CH_W:0]      cfg_wdata = '0;
    logic [CH_W:0]      cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    timer_adc_xtrig #(.NUM_EVT(NUM_EVT), .CH_W(CH_W)) u_timer_adc_xtrig (
        .clk(clk), .rst_n(rst_n), .evt_flag(evt_flag), .evt_ack(evt_ack),
        .adc_busy(adc_busy), .adc_done(adc_done), .adc_trig(adc_trig),
        .adc_chan(adc_chan), .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        tick();
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = (CH_W+1)'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        cfg_addr = AW'(addr);
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic done_pulse();
        tick(); adc_done = 1'b1;
        tick(); adc_done = 1'b0;
    endtask

    function automatic int route_ch(input int i);
        return (i * 7 + 3) % 64;
    endfunction

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 trig", adc_trig, 0);
        chk("R1 ack", evt_ack, 0);
        chk("R1 irq", irq, 0);
        rd_chk("R1 route0", 0, 0);
        rd_chk("R1 irqen", NUM_EVT, 0);

        // R2 register write and readback over every route
        for (int i = 0; i < NUM_EVT; i++) wr(i, ((i % 3 == 0) ? 64 : 0) + route_ch(i));
        wr(NUM_EVT, 1);
        for (int i = 0; i < NUM_EVT; i++) rd_chk("R2 route", i, ((i % 3 == 0) ? 64 : 0) + route_ch(i));
        rd_chk("R2 irqen", NUM_EVT, 1);

        // R3 R4 R10 sweep of each event through the full handshake
        for (int i = 0; i < NUM_EVT; i++) begin
            wr(i, 64 + route_ch(i));
            wr(NUM_EVT, i % 2);
            tick(); evt_flag[i] = 1'b1;
            tick();
            chk("R3 ack", evt_ack, longint'(1) << i);
            chk("R4 early trig", adc_trig, 0);
            tick();
            chk("R3 ack one cycle", evt_ack, 0);
            chk("R4 trig", adc_trig, 1);
            chk("R4 chan", adc_chan, route_ch(i));
            chk("R10 irq", irq, i % 2);
            tick();
            chk("R4 trig width", adc_trig, 0);
            chk("R10 irq low", irq, 0);
            evt_flag[i] = 1'b0;
            adc_done = 1'b1;
            tick(); adc_done = 1'b0;
        end

        // R5 disabled route is ignored
        wr(7, 5);
        tick(); evt_flag[7] = 1'b1;
        tick();
        chk("R5 no ack", evt_ack, 0);
        n = 0;
        for (int k = 0; k < 5; k++) begin tick(); n += adc_trig; end
        chk("R5 no trig", n, 0);
        evt_flag[7] = 1'b0;

        // R6 busy holds the trigger back
        wr(4, 64 + 9);
        tick(); adc_busy = 1'b1; evt_flag[4] = 1'b1;
        n = 0;
        for (int k = 0; k < 6; k++) begin tick(); n += adc_trig; end
        chk("R6 held", n, 0);
        adc_busy = 1'b0;
        tick();
        chk("R6 fire after busy", adc_trig, 1);
        chk("R6 chan", adc_chan, 9);
        evt_flag[4] = 1'b0;
        done_pulse();

        // R7 R8 simultaneous events, ascending order
        wr(5, 64 + 11); wr(11, 64 + 22); wr(20, 64 + 33);
        tick(); evt_flag[20] = 1'b1; evt_flag[5] = 1'b1; evt_flag[11] = 1'b1;
        tick();
        chk("R3 multi ack", evt_ack, (longint'(1) << 5) | (longint'(1) << 11) | (longint'(1) << 20));
        tick();
        chk("R8 first trig", adc_trig, 1);
        chk("R8 first chan", adc_chan, 11);
        evt_flag = '0;
        n = 0;
        for (int k = 0; k < 4; k++) begin tick(); n += adc_trig; end
        chk("R7 wait for done", n, 0);
        done_pulse();
        chk("R7 not yet", adc_trig, 0);
        tick();
        chk("R8 second trig", adc_trig, 1);
        chk("R8 second chan", adc_chan, 22);
        done_pulse();
        tick();
        chk("R8 third trig", adc_trig, 1);
        chk("R8 third chan", adc_chan, 33);
        done_pulse();
        n = 0;
        for (int k = 0; k < 5; k++) begin tick(); n += adc_trig; end
        chk("R8 drained", n, 0);

        // R9 repeated rise while pending merges
        wr(3, 64 + 17);
        tick(); adc_busy = 1'b1; evt_flag[3] = 1'b1;
        tick(); evt_flag[3] = 1'b0;
        tick(); evt_flag[3] = 1'b1;
        tick(); evt_flag[3] = 1'b0;
        tick(); adc_busy = 1'b0;
        tick();
        chk("R9 trig", adc_trig, 1);
        chk("R9 chan", adc_chan, 17);
        done_pulse();
        n = 0;
        for (int k = 0; k < 6; k++) begin tick(); n += adc_trig; end
        chk("R9 single trig", n, 0);

        // R11 held-high flag yields one event
        wr(2, 64 + 40);
        tick(); evt_flag[2] = 1'b1;
        tick(); tick();
        chk("R11 trig", adc_trig, 1);
        done_pulse();
        n = 0;
        for (int k = 0; k < 6; k++) begin tick(); n += adc_trig; end
        chk("R11 no retrigger", n, 0);
        evt_flag[2] = 1'b0;
        tick();

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule